// File: doc/BRIEF.md
# Aligning Floating Add/Subtract Datapath

This block performs the front half of a floating add or subtract on operands made of an 18-bit two's-complement exponent, a sign bit and a 35-bit magnitude fraction. After a start pulse it compares the exponents. It right-shifts the fraction of the operand with the smaller exponent one place per cycle, and each bit that leaves the fraction enters the top of a 35-bit spill register. It then optionally rounds the shifted fraction from the first bit that was shifted out, and adds or subtracts the magnitudes. A carry out of the sum is folded back with a guard bit. Last, it applies a 2-bit sign modifier to the result.

When one operand is zero, or when the exponents are so far apart that the smaller operand cannot reach the result, no shifting takes place and the result is ready after one cycle. The raw result, the spill register and the guard flag are handed to a separate normalizer. A one-cycle `done_o` pulse tells that normalizer that these values are valid. They then hold until the next accepted start.

Top module: `fp_align_addsub`

## Requirements
- R1: After reset, every result output, the spill register and the guard flag are zero, and done is low.
- R2: With d = expA - expB (signed), if A's fraction is zero or d < -35, the result is B's exponent and fraction, and B's sign is inverted when sub_i is 1. Done pulses one cycle after start.
- R3: If R2 does not apply and either B's fraction is zero or d > 35, the result is A's exponent, sign and fraction. Done pulses one cycle after start.
- R4: Otherwise the fraction of the operand with the smaller exponent (B when d >= 0) is shifted right by |d| places, one place per cycle. The bits shifted out enter spill bit 34 and move downward, so that after the shift the spill holds them in their original order at the top. The result exponent is the larger one. Done pulses |d|+2 cycles after start.
- R5: After alignment, if no_round_i is 0 and spill bit 34 is 1, the shifted fraction is incremented by one before the add or subtract.
- R6: An effective subtract (signA XOR signB XOR sub_i equal to 1) yields the larger magnitude minus the smaller. The result sign is signA, inverted when |A| < |B| after rounding.
- R7: An effective add whose 36-bit sum has bit 35 set sets guard to the sum's bit 0, shifts the sum right by one and adds one to the exponent (modulo 2^18). It then adds one to the fraction when no_round_i is 0 and guard is 1. Without a carry, guard is 0.
- R8: An accepted start clears the spill register and the guard flag on the following edge.
- R9: The sign modifier sign_mod_i is applied last: 0 keeps the sign, 1 clears it, 2 sets it, 3 inverts it.
- R10: A start pulse that arrives while an alignment is in progress is ignored, and the operation in flight completes with its own operands.
- R11: done_o is a one-cycle pulse. The result outputs change only on the edge that raises done and hold their values until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation with the present inputs |
| a_exp_i | input | 18 | Exponent of A, two's complement |
| a_sign_i | input | 1 | Sign of A (1 = negative) |
| a_frac_i | input | 35 | Fraction magnitude of A |
| b_exp_i | input | 18 | Exponent of B, two's complement |
| b_sign_i | input | 1 | Sign of B |
| b_frac_i | input | 35 | Fraction magnitude of B |
| sub_i | input | 1 | 1 = subtract B from A |
| no_round_i | input | 1 | 1 = suppress both rounding increments |
| sign_mod_i | input | 2 | Sign modifier applied to the result |
| res_exp_o | output | 18 | Result exponent |
| res_sign_o | output | 1 | Result sign |
| res_frac_o | output | 35 | Result fraction, not normalized |
| spill_o | output | 35 | Bits shifted out during alignment |
| guard_o | output | 1 | Bit lost by the carry shift |
| done_o | output | 1 | One-cycle pulse: outputs are valid |

## Verification
On every cycle, the assertions check that done is a single-cycle pulse and that the result outputs move only when done rises. They also check that an accepted start clears spill and guard, that spill stays still while the block is idle, and that a set guard always comes with a result whose top fraction bit is 1. The actual arithmetic can only be shown by the bench's scenarios, because a property cannot express it. That covers the selection of a bypass operand, the exact spill contents for a given shift distance, the rounding increment, magnitude-ordered subtraction with its sign flip, carry folding, each sign-modifier code, the latency per shift distance, and the start that is ignored while busy.

// File: rtl/fp_align_pkg.sv
package fp_align_pkg;

    typedef enum logic [0:0] {
        PH_IDLE  = 1'b0,
        PH_ALIGN = 1'b1
    } phase_t;

    typedef enum logic [1:0] {
        SM_KEEP  = 2'd0,
        SM_CLEAR = 2'd1,
        SM_SET   = 2'd2,
        SM_FLIP  = 2'd3
    } sign_mod_t;

    function automatic logic sign_adjust(input logic s, input logic [1:0] m);
        logic r;
        case (sign_mod_t'(m))
            SM_CLEAR: r = 1'b0;
            SM_SET:   r = 1'b1;
            SM_FLIP:  r = ~s;
            default:  r = s;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fp_align_bypass.sv
module fp_align_bypass #(
    parameter int FRAC_W = 35,
    parameter int DIF_W  = 19
) (
    input  logic                     a_zero_i,
    input  logic                     b_zero_i,
    input  logic signed [DIF_W-1:0]  diff_i,
    output logic                     take_b_o,
    output logic                     take_a_o
);
    localparam logic signed [DIF_W-1:0] REACH = DIF_W'(FRAC_W);

    logic far_below;
    logic far_above;

    always_comb begin
        far_below = diff_i < -REACH;
        far_above = diff_i > REACH;
        take_b_o  = a_zero_i || far_below;
        take_a_o  = !take_b_o && (b_zero_i || far_above);
    end
endmodule

// File: rtl/fp_align_rshift.sv
module fp_align_rshift #(
    parameter int FRAC_W = 35
) (
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [FRAC_W-1:0] spill_i,
    output logic [FRAC_W-1:0] frac_o,
    output logic [FRAC_W-1:0] spill_o
);
    always_comb begin
        frac_o  = {1'b0, frac_i[FRAC_W-1:1]};
        spill_o = {frac_i[0], spill_i[FRAC_W-1:1]};
    end
endmodule

// File: rtl/fp_align_combine.sv
module fp_align_combine
    import fp_align_pkg::*;
#(
    parameter int EXP_W  = 18,
    parameter int FRAC_W = 35
) (
    input  logic [FRAC_W-1:0] fa_i,
    input  logic [FRAC_W-1:0] fb_i,
    input  logic              shifted_b_i,
    input  logic              spill_top_i,
    input  logic              no_round_i,
    input  logic              eff_sub_i,
    input  logic              sign_a_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [1:0]        sign_mod_i,
    output logic [FRAC_W-1:0] frac_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic              sign_o,
    output logic              guard_o
);
    logic              rnd;
    logic [FRAC_W-1:0] ra;
    logic [FRAC_W-1:0] rb;
    logic              a_less;
    logic [FRAC_W:0]   sum;
    logic              raw_sign;
    logic              lost;

    always_comb begin
        rnd      = !no_round_i && spill_top_i;
        ra       = fa_i + FRAC_W'(rnd && !shifted_b_i);
        rb       = fb_i + FRAC_W'(rnd && shifted_b_i);
        a_less   = ra < rb;
        sum      = {1'b0, ra} + {1'b0, rb};
        lost     = 1'b0;
        exp_o    = exp_i;
        raw_sign = sign_a_i;
        if (eff_sub_i) begin
            frac_o   = a_less ? (rb - ra) : (ra - rb);
            raw_sign = sign_a_i ^ a_less;
        end else if (sum[FRAC_W]) begin
            lost   = sum[0];
            exp_o  = exp_i + EXP_W'(1);
            frac_o = sum[FRAC_W:1] + FRAC_W'(!no_round_i && sum[0]);
        end else begin
            frac_o = sum[FRAC_W-1:0];
        end
        guard_o = lost;
        sign_o  = sign_adjust(raw_sign, sign_mod_i);
    end
endmodule

// File: rtl/fp_align_addsub.sv
module fp_align_addsub
    import fp_align_pkg::*;
#(
    parameter int EXP_W  = 18,
    parameter int FRAC_W = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [EXP_W-1:0]  a_exp_i,
    input  logic              a_sign_i,
    input  logic [FRAC_W-1:0] a_frac_i,
    input  logic [EXP_W-1:0]  b_exp_i,
    input  logic              b_sign_i,
    input  logic [FRAC_W-1:0] b_frac_i,
    input  logic              sub_i,
    input  logic              no_round_i,
    input  logic [1:0]        sign_mod_i,
    output logic [EXP_W-1:0]  res_exp_o,
    output logic              res_sign_o,
    output logic [FRAC_W-1:0] res_frac_o,
    output logic [FRAC_W-1:0] spill_o,
    output logic              guard_o,
    output logic              done_o
);
    localparam int DIF_W = EXP_W + 1;
    localparam int CNT_W = $clog2(FRAC_W + 1);

    typedef struct packed {
        phase_t             phase;
        logic [CNT_W-1:0]   cnt;
        logic [FRAC_W-1:0]  wa;
        logic [FRAC_W-1:0]  wb;
        logic [EXP_W-1:0]   wexp;
        logic               sa;
        logic               sb;
        logic               sub;
        logic               nornd;
        logic [1:0]         smod;
        logic               shift_b;
        logic [FRAC_W-1:0]  spill;
        logic [EXP_W-1:0]   rexp;
        logic               rsign;
        logic [FRAC_W-1:0]  rfrac;
        logic               guard;
        logic               done;
    } regs_t;

    regs_t q, d;

    logic signed [DIF_W-1:0] diff;
    logic [DIF_W-1:0]        diff_mag;
    logic                    take_b;
    logic                    take_a;
    logic                    busy;

    logic [FRAC_W-1:0] sh_in;
    logic [FRAC_W-1:0] sh_frac;
    logic [FRAC_W-1:0] sh_spill;

    logic [FRAC_W-1:0] cb_frac;
    logic [EXP_W-1:0]  cb_exp;
    logic              cb_sign;
    logic              cb_guard;

    always_comb begin
        diff     = $signed({a_exp_i[EXP_W-1], a_exp_i}) - $signed({b_exp_i[EXP_W-1], b_exp_i});
        diff_mag = diff[DIF_W-1] ? DIF_W'(-diff) : DIF_W'(diff);
        busy     = (q.phase == PH_ALIGN);
        sh_in    = q.shift_b ? q.wb : q.wa;
    end

    fp_align_bypass #(.FRAC_W(FRAC_W), .DIF_W(DIF_W)) u_bypass (
        .a_zero_i (a_frac_i == '0),
        .b_zero_i (b_frac_i == '0),
        .diff_i   (diff),
        .take_b_o (take_b),
        .take_a_o (take_a)
    );

    fp_align_rshift #(.FRAC_W(FRAC_W)) u_shift (
        .frac_i  (sh_in),
        .spill_i (q.spill),
        .frac_o  (sh_frac),
        .spill_o (sh_spill)
    );

    fp_align_combine #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_combine (
        .fa_i        (q.wa),
        .fb_i        (q.wb),
        .shifted_b_i (q.shift_b),
        .spill_top_i (q.spill[FRAC_W-1]),
        .no_round_i  (q.nornd),
        .eff_sub_i   (q.sa ^ q.sb ^ q.sub),
        .sign_a_i    (q.sa),
        .exp_i       (q.wexp),
        .sign_mod_i  (q.smod),
        .frac_o      (cb_frac),
        .exp_o       (cb_exp),
        .sign_o      (cb_sign),
        .guard_o     (cb_guard)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    d.spill = '0;
                    d.guard = 1'b0;
                    if (take_b) begin
                        d.rexp  = b_exp_i;
                        d.rfrac = b_frac_i;
                        d.rsign = sign_adjust(b_sign_i ^ sub_i, sign_mod_i);
                        d.done  = 1'b1;
                    end else if (take_a) begin
                        d.rexp  = a_exp_i;
                        d.rfrac = a_frac_i;
                        d.rsign = sign_adjust(a_sign_i, sign_mod_i);
                        d.done  = 1'b1;
                    end else begin
                        d.phase   = PH_ALIGN;
                        d.wa      = a_frac_i;
                        d.wb      = b_frac_i;
                        d.sa      = a_sign_i;
                        d.sb      = b_sign_i;
                        d.sub     = sub_i;
                        d.nornd   = no_round_i;
                        d.smod    = sign_mod_i;
                        d.shift_b = !diff[DIF_W-1];
                        d.wexp    = diff[DIF_W-1] ? b_exp_i : a_exp_i;
                        d.cnt     = diff_mag[CNT_W-1:0];
                    end
                end
            end
            PH_ALIGN: begin
                if (q.cnt != '0) begin
                    d.cnt   = q.cnt - CNT_W'(1);
                    d.spill = sh_spill;
                    if (q.shift_b) begin
                        d.wb = sh_frac;
                    end else begin
                        d.wa = sh_frac;
                    end
                end else begin
                    d.rfrac = cb_frac;
                    d.rexp  = cb_exp;
                    d.rsign = cb_sign;
                    d.guard = cb_guard;
                    d.done  = 1'b1;
                    d.phase = PH_IDLE;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign res_exp_o  = q.rexp;
    assign res_sign_o = q.rsign;
    assign res_frac_o = q.rfrac;
    assign spill_o    = q.spill;
    assign guard_o    = q.guard;
    assign done_o     = q.done;
endmodule

// File: rtl/fp_align_addsub_chk.sv
module fp_align_addsub_chk #(
    parameter int EXP_W  = 18,
    parameter int FRAC_W = 35
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy,
    input logic [EXP_W-1:0]  res_exp_o,
    input logic              res_sign_o,
    input logic [FRAC_W-1:0] res_frac_o,
    input logic [FRAC_W-1:0] spill_o,
    input logic              guard_o,
    input logic              done_o
);
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(res_frac_o) && $stable(res_exp_o) && $stable(res_sign_o)));

    a_r8_spill_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |=> (spill_o == '0));

    a_r8_guard_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |=> !guard_o);

    a_r10_idle_spill: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_i) |=> $stable(spill_o));

    a_r7_guard_top: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && guard_o) |-> res_frac_o[FRAC_W-1]);
endmodule

bind fp_align_addsub fp_align_addsub_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy       (busy),
    .res_exp_o  (res_exp_o),
    .res_sign_o (res_sign_o),
    .res_frac_o (res_frac_o),
    .spill_o    (spill_o),
    .guard_o    (guard_o),
    .done_o     (done_o)
);

// File: tb/sim_fp_align_addsub.sv
module sim_fp_align_addsub;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [17:0] a_exp_i, b_exp_i;
    logic        a_sign_i, b_sign_i;
    logic [34:0] a_frac_i, b_frac_i;
    logic        sub_i, no_round_i;
    logic [1:0]  sign_mod_i;
    logic [17:0] res_exp_o;
    logic        res_sign_o;
    logic [34:0] res_frac_o;
    logic [34:0] spill_o;
    logic        guard_o;
    logic        done_o;

    int checks = 0;
    int failures = 0;

    logic [17:0] e_exp;
    logic        e_sign;
    logic [34:0] e_frac;
    logic [34:0] e_spill;
    logic        e_guard;
    int          e_lat;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_align_addsub u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .a_exp_i(a_exp_i), .a_sign_i(a_sign_i), .a_frac_i(a_frac_i),
        .b_exp_i(b_exp_i), .b_sign_i(b_sign_i), .b_frac_i(b_frac_i),
        .sub_i(sub_i), .no_round_i(no_round_i), .sign_mod_i(sign_mod_i),
        .res_exp_o(res_exp_o), .res_sign_o(res_sign_o), .res_frac_o(res_frac_o),
        .spill_o(spill_o), .guard_o(guard_o), .done_o(done_o)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic smod(logic s, logic [1:0] m);
        case (m)
            2'd1: return 1'b0;
            2'd2: return 1'b1;
            2'd3: return ~s;
            default: return s;
        endcase
    endfunction

    task automatic model(logic [17:0] ae, logic as_, logic [34:0] af,
                         logic [17:0] be, logic bs, logic [34:0] bf,
                         logic sb, logic nr, logic [1:0] sm);
        int dd;
        int sd;
        logic [69:0] wide;
        logic [34:0] x, y;
        logic [35:0] s;
        logic sg;
        dd = int'($signed(ae)) - int'($signed(be));
        e_spill = '0;
        e_guard = 1'b0;
        if (af == 0 || dd < -35) begin
            e_exp = be; e_frac = bf; e_sign = smod(bs ^ sb, sm); e_lat = 1;
        end else if (bf == 0 || dd > 35) begin
            e_exp = ae; e_frac = af; e_sign = smod(as_, sm); e_lat = 1;
        end else begin
            sd    = (dd < 0) ? -dd : dd;
            e_lat = sd + 2;
            e_exp = (dd < 0) ? be : ae;
            wide  = {((dd < 0) ? af : bf), 35'd0} >> sd;
            e_spill = wide[34:0];
            if (dd < 0) begin x = wide[69:35]; y = bf; end
            else begin x = af; y = wide[69:35]; end
            if (!nr && e_spill[34]) begin
                if (dd < 0) x = x + 35'd1; else y = y + 35'd1;
            end
            sg = as_;
            if (as_ ^ bs ^ sb) begin
                if (x < y) begin e_frac = y - x; sg = ~as_; end
                else e_frac = x - y;
            end else begin
                s = {1'b0, x} + {1'b0, y};
                if (s[35]) begin
                    e_guard = s[0];
                    e_exp   = e_exp + 18'd1;
                    e_frac  = s[35:1] + ((!nr && s[0]) ? 35'd1 : 35'd0);
                end else e_frac = s[34:0];
            end
            e_sign = smod(sg, sm);
        end
    endtask

    task automatic run_op(string tag, logic [17:0] ae, logic as_, logic [34:0] af,
                          logic [17:0] be, logic bs, logic [34:0] bf,
                          logic sb, logic nr, logic [1:0] sm, bit poke);
        int lat;
        bit seen;
        model(ae, as_, af, be, bs, bf, sb, nr, sm);
        @(negedge clk);
        a_exp_i = ae; a_sign_i = as_; a_frac_i = af;
        b_exp_i = be; b_sign_i = bs; b_frac_i = bf;
        sub_i = sb; no_round_i = nr; sign_mod_i = sm;
        start_i = 1'b1;
        lat = 0;
        seen = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            lat++;
            start_i = 1'b0;
            if (poke && lat == 1) begin
                a_exp_i = ~ae; a_frac_i = ~af; b_frac_i = 35'h1; sub_i = ~sb;
                start_i = 1'b1;
            end
            if (done_o) begin seen = 1'b1; break; end
        end
        start_i = 1'b0;
        if (!seen) begin
            failures++;
            checks++;
            $display("FAIL %s watchdog actual=%0h expected=%0h", tag, 0, 1);
            return;
        end
        check(tag, "latency", 64'(lat), 64'(e_lat));
        check(tag, "frac", 64'(res_frac_o), 64'(e_frac));
        check(tag, "exp", 64'(res_exp_o), 64'(e_exp));
        check(tag, "sign", 64'(res_sign_o), 64'(e_sign));
        check(tag, "spill", 64'(spill_o), 64'(e_spill));
        check(tag, "guard", 64'(guard_o), 64'(e_guard));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog global actual=%0h expected=%0h", 0, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0;
        a_exp_i = '0; a_sign_i = 0; a_frac_i = '0;
        b_exp_i = '0; b_sign_i = 0; b_frac_i = '0;
        sub_i = 0; no_round_i = 0; sign_mod_i = '0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", "outputs", {res_exp_o, res_sign_o, guard_o, done_o}, 64'd0);
        check("R1", "frac/spill", {res_frac_o, 29'd0} | 64'(spill_o), 64'd0);
        rst_n = 1'b1;

        // R2: A zero, subtract inverts B sign; and far below
        run_op("R2", 18'd5, 1'b0, 35'd0, 18'd9, 1'b0, 35'h4_0000_0003, 1'b1, 1'b0, 2'd0, 0);
        run_op("R2", 18'd0, 1'b1, 35'h5_5555_5555, 18'd36, 1'b1, 35'h4_0000_0000, 1'b1, 1'b0, 2'd0, 0);
        // R3: B zero, and far above
        run_op("R3", 18'h3FFF0, 1'b1, 35'h4_1234_5678, 18'd7, 1'b0, 35'd0, 1'b1, 1'b0, 2'd0, 0);
        run_op("R3", 18'd36, 1'b0, 35'h4_0000_0001, 18'd0, 1'b1, 35'h7_FFFF_FFFF, 1'b0, 1'b0, 2'd0, 0);
        // R4: spill order with rounding off, A smaller
        run_op("R4", 18'd2, 1'b0, 35'h7, 18'd5, 1'b0, 35'h4_0000_0000, 1'b0, 1'b1, 2'd0, 0);
        // R4: shift of exactly 35
        run_op("R4", 18'd40, 1'b0, 35'h4_0000_0000, 18'd5, 1'b0, 35'h6_0000_0001, 1'b0, 1'b1, 2'd0, 0);
        // R5: same as first R4 case with rounding on
        run_op("R5", 18'd2, 1'b0, 35'h7, 18'd5, 1'b0, 35'h4_0000_0000, 1'b0, 1'b0, 2'd0, 0);
        // R6: |A| < |B| on effective subtract flips sign
        run_op("R6", 18'd3, 1'b0, 35'h1_0000_0000, 18'd3, 1'b1, 35'h5_0000_0000, 1'b0, 1'b0, 2'd0, 0);
        run_op("R6", 18'd3, 1'b1, 35'h5_0000_0000, 18'd3, 1'b1, 35'h1_0000_0000, 1'b1, 1'b0, 2'd0, 0);
        // R7: carry with guard 1, rounding on and off
        run_op("R7", 18'h3FFFF, 1'b0, 35'h7_FFFF_FFFF, 18'h3FFFF, 1'b0, 35'h4_0000_0000, 1'b0, 1'b0, 2'd0, 0);
        run_op("R7", 18'h1FFFF, 1'b0, 35'h7_FFFF_FFFF, 18'h1FFFF, 1'b0, 35'h4_0000_0000, 1'b0, 1'b1, 2'd0, 0);
        // R8: previous op left guard set; a new aligned op must clear it
        run_op("R8", 18'd4, 1'b0, 35'h4_0000_0000, 18'd1, 1'b0, 35'h4_0000_0000, 1'b0, 1'b0, 2'd0, 0);
        // R9: each sign-modifier code
        for (int m = 0; m < 4; m++) begin
            run_op("R9", 18'd1, 1'b1, 35'h4_0000_0000, 18'd0, 1'b1, 35'h4_0000_0000, 1'b0, 1'b0, 2'(m), 0);
        end
        // R10: start pulsed while aligning is ignored
        run_op("R10", 18'd10, 1'b0, 35'h4_AAAA_0000, 18'd4, 1'b1, 35'h5_0000_0F0F, 1'b0, 1'b0, 2'd0, 1);
        // R11: outputs hold after done
        repeat (3) @(negedge clk);
        check("R11", "hold frac", 64'(res_frac_o), 64'(e_frac));
        check("R11", "hold done low", 64'(done_o), 64'd0);

        // Random mix (R4, R5, R6, R7, R9)
        void'($urandom(32'd20240611));
        for (int k = 0; k < 300; k++) begin
            logic [17:0] ae, be;
            logic [34:0] af, bf;
            int delta;
            ae = 18'($urandom_range(2000)) - 18'd1000;
            delta = int'($urandom_range(80)) - 40;
            be = ae - 18'(delta);
            af = {$urandom, $urandom};
            bf = {$urandom, $urandom};
            if ($urandom_range(3) != 0) af[34] = 1'b1;
            if ($urandom_range(3) != 0) bf[34] = 1'b1;
            if ($urandom_range(30) == 0) af = '0;
            if ($urandom_range(30) == 0) bf = '0;
            run_op("R4", ae, 1'($urandom), af, be, 1'($urandom), bf,
                   1'($urandom), 1'($urandom), 2'($urandom), 0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule